// File: doc/BRIEF.md
# Serial Management Slave Endpoint

This block is the device-side end of a two-wire serial management link. The controller supplies a clock, `mdc`. Both sides share one bidirectional data line, which is split here into an input, an output and an output enable for the pad. Every input is sampled on the rising edge of `mdc`. The block searches for a run of ones that marks a preamble, then decodes the start pattern, an operation code, a device address and a register address. It acts only on frames addressed to the 3-bit address set by straps.

A matched write captures 16 data bits and stores them in an internal file of 32 registers of 16 bits each. A one-cycle strobe with the register index and data is also presented at the ports. A matched read releases the line for the first turnaround bit, then drives a zero, then sends the selected register's 16 bits most significant bit first. Each output change is launched just after a rising edge.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones sampled on `mdio_i`, followed by the start bits 0 then 1. A run of 31 ones followed by a start pattern causes no register access and no driving.
- R2: If a non-01 start pattern follows the preamble, the block returns to preamble search. Header bits that follow without a fresh 32-one preamble are ignored, and a later correct frame is accepted.
- R3: Opcode bits are sent first bit first: 10 means read and 01 means write. The codes 00 and 11 cause neither a strobe nor any driving.
- R4: The 5-bit device address is sent MSB first. It matches only when bits 4:3 are 00 and bits 2:0 equal `strap_addr`. A frame with any other address produces no strobe, no driving and no register change.
- R5: Device address 0 is an ordinary address. A write to address 0 reaches a block strapped to 0 only, and leaves other blocks' registers unchanged.
- R6: The 5-bit register address, sent MSB first, selects one of 32 registers. A read returns the value most recently written to that register.
- R7: In a matched read, `mdio_oe` is low during the first turnaround bit. It rises after the rising edge that samples that bit, with `mdio_o` = 0 for the second turnaround bit.
- R8: In a matched read, the 16 data bits follow MSB first, one per `mdc` cycle. `mdio_oe` stays high for exactly 17 cycles and falls after the edge that samples the last data bit.
- R9: During a write frame the block never asserts `mdio_oe`. It captures the 16 data bits that follow the two turnaround bits, MSB first.
- R10: `wr_stb` is high for exactly one cycle, starting at the rising edge that samples the 16th data bit of a matched write. During that cycle `wr_reg` and `wr_data` carry the register index and the data.
- R11: While `rst_n` is low and right after reset, `mdio_oe` and `wr_stb` are 0 and all 32 registers read as 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 3 | Strapped device address |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Tri-state enable for the data line pad |
| wr_stb | output | 1 | One-cycle write strobe for a matched write |
| wr_reg | output | 5 | Register index of the write |
| wr_data | output | 16 | Data of the write |

## Verification
Assertions check, on every cycle, that the write strobe never lasts beyond one cycle and never coincides with driving. They also check that every driven span starts with a zero and lasts exactly 17 cycles. Only the bench scenarios can show address matching, rejection of bad opcodes, preamble length, recovery from a bad start pattern, and correct read-back of the data. The bench covers these by sweeping all strap values over all 32 registers, and by sending frames to foreign addresses, to address 0 and with malformed framing.

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int DATA_W  = 16,
  parameter int RA_W    = 5,
  parameter int PA_W    = 5,
  parameter int STRAP_W = 3,
  parameter int PRE_LEN = 32
) (
  input  logic               mdc,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               wr_stb,
  output logic [RA_W-1:0]    wr_reg,
  output logic [DATA_W-1:0]  wr_data
);
  localparam int NREGS = 1 << RA_W;
  localparam int HDR_W = 2 + PA_W + RA_W;
  localparam int PC_W  = $clog2(PRE_LEN + 1);
  localparam int BC_W  = $clog2(((HDR_W > DATA_W) ? HDR_W : DATA_W) + 2);
  localparam int OL_W  = $clog2(DATA_W + 3);
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef enum logic [2:0] {S_HUNT, S_PRE, S_START, S_HDR, S_RTA, S_RDAT, S_WTA, S_WDAT} st_t;

  st_t               st;
  logic [PC_W-1:0]   pcnt;
  logic [BC_W-1:0]   bcnt;
  logic [HDR_W-2:0]  hdr_sr;
  logic [DATA_W-1:0] dsr;
  logic [RA_W-1:0]   rsel;
  logic [DATA_W-1:0] mem [NREGS];

  wire [HDR_W-1:0] hdr_full = {hdr_sr, mdio_i};
  wire [1:0]       hdr_op   = hdr_full[HDR_W-1 -: 2];
  wire [PA_W-1:0]  hdr_pa   = hdr_full[RA_W +: PA_W];
  wire [RA_W-1:0]  hdr_ra   = hdr_full[RA_W-1:0];
  wire addr_hit = ((hdr_pa >> STRAP_W) == '0) && (hdr_pa[STRAP_W-1:0] == strap_addr);

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_HUNT;
      pcnt    <= '0;
      bcnt    <= '0;
      hdr_sr  <= '0;
      dsr     <= '0;
      rsel    <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      wr_stb  <= 1'b0;
      wr_reg  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      case (st)
        S_HUNT: begin
          if (!mdio_i) pcnt <= '0;
          else if (pcnt == PC_W'(PRE_LEN - 1)) begin
            pcnt <= '0;
            st   <= S_PRE;
          end else pcnt <= pcnt + 1'b1;
        end
        S_PRE:   if (!mdio_i) st <= S_START;
        S_START: begin
          bcnt <= '0;
          st   <= mdio_i ? S_HDR : S_HUNT;
        end
        S_HDR: begin
          hdr_sr <= hdr_full[HDR_W-2:0];
          bcnt   <= bcnt + 1'b1;
          if (bcnt == BC_W'(HDR_W - 1)) begin
            bcnt <= '0;
            rsel <= hdr_ra;
            if (addr_hit && hdr_op == OP_RD)      st <= S_RTA;
            else if (addr_hit && hdr_op == OP_WR) st <= S_WTA;
            else                                  st <= S_HUNT;
          end
        end
        S_RTA: begin
          mdio_oe <= 1'b1;
          mdio_o  <= 1'b0;
          dsr     <= mem[rsel];
          bcnt    <= '0;
          st      <= S_RDAT;
        end
        S_RDAT: begin
          if (bcnt == BC_W'(DATA_W)) begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
            bcnt    <= '0;
            st      <= S_HUNT;
          end else begin
            mdio_o <= dsr[DATA_W-1];
            dsr    <= dsr << 1;
            bcnt   <= bcnt + 1'b1;
          end
        end
        S_WTA: begin
          if (bcnt == BC_W'(1)) begin
            bcnt <= '0;
            st   <= S_WDAT;
          end else bcnt <= bcnt + 1'b1;
        end
        S_WDAT: begin
          dsr  <= {dsr[DATA_W-2:0], mdio_i};
          bcnt <= bcnt + 1'b1;
          if (bcnt == BC_W'(DATA_W - 1)) begin
            wr_stb  <= 1'b1;
            wr_reg  <= rsel;
            wr_data <= {dsr[DATA_W-2:0], mdio_i};
            bcnt    <= '0;
            st      <= S_HUNT;
          end
        end
        default: st <= S_HUNT;
      endcase
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (wr_stb) begin
      mem[wr_reg] <= wr_data;
    end
  end

  logic [OL_W-1:0] oe_len;
  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n)       oe_len <= '0;
    else if (mdio_oe) oe_len <= oe_len + 1'b1;
    else              oe_len <= '0;
  end

  AST_STB_ONE_CYCLE: assert property (@(posedge mdc) disable iff (!rst_n) wr_stb |=> !wr_stb); // R10
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge mdc) disable iff (!rst_n) wr_stb |-> !mdio_oe); // R9
  AST_TA_DRIVES_ZERO: assert property (@(posedge mdc) disable iff (!rst_n) $rose(mdio_oe) |-> !mdio_o); // R7
  AST_DRIVE_SPAN: assert property (@(posedge mdc) disable iff (!rst_n) $fell(mdio_oe) |-> oe_len == OL_W'(DATA_W + 1)); // R8
endmodule

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;
  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  strap = 3'd0;
  logic        mst_en = 1'b0;
  logic        mst_v = 1'b1;
  logic        mdio_o, mdio_oe, wr_stb;
  logic [4:0]  wr_reg;
  logic [15:0] wr_data;
  wire         bus = mdio_oe ? mdio_o : (mst_en ? mst_v : 1'b1);

  int n_chk = 0, n_fail = 0, stb_cnt = 0, oe_cnt = 0;
  logic [15:0] expv [32];

  always #2 mdc = ~mdc;

  mdio_mgmt_slave u_dut (
    .mdc(mdc), .rst_n(rst_n), .strap_addr(strap), .mdio_i(bus),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .wr_stb(wr_stb), .wr_reg(wr_reg), .wr_data(wr_data)
  );

  always @(negedge mdc) begin
    if (wr_stb)  stb_cnt++;
    if (mdio_oe) oe_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic b);
    @(negedge mdc);
    mst_en = 1'b1;
    mst_v  = b;
  endtask

  task automatic preamble(input int n);
    for (int i = 0; i < n; i++) put(1'b1);
  endtask

  task automatic header(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
    put(1'b0); put(1'b1);
    for (int i = 1; i >= 0; i--) put(op[i]);
    for (int i = 4; i >= 0; i--) put(pa[i]);
    for (int i = 4; i >= 0; i--) put(ra[i]);
  endtask

  task automatic do_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d,
                          input bit hit, input string req);
    int s0, o0;
    s0 = stb_cnt; o0 = oe_cnt;
    preamble(32);
    header(2'b01, pa, ra);
    put(1'b1); put(1'b0);
    for (int i = 15; i >= 0; i--) put(d[i]);
    @(negedge mdc);
    mst_en = 1'b0;
    if (hit) begin
      chk(wr_stb === 1'b1, "R10 strobe", int'(wr_stb), 1);
      chk(wr_reg === ra && wr_data === d, "R9 captured data", int'(wr_data), int'(d));
      @(negedge mdc);
      chk(wr_stb === 1'b0, "R10 strobe width", int'(wr_stb), 0);
      chk(oe_cnt == o0, "R9 no drive in write", oe_cnt - o0, 0);
    end else begin
      repeat (2) @(negedge mdc);
      chk(stb_cnt == s0 && oe_cnt == o0, req, stb_cnt - s0 + oe_cnt - o0, 0);
    end
  endtask

  task automatic do_read(input logic [4:0] pa, input logic [4:0] ra, input bit hit,
                         input string req, output logic [15:0] d);
    int o0;
    bit ta1, ta2, span;
    o0 = oe_cnt; d = '0; ta1 = 1; ta2 = 1; span = 1;
    preamble(32);
    header(2'b10, pa, ra);
    for (int k = 1; k <= 19; k++) begin
      @(negedge mdc);
      mst_en = 1'b0;
      if (k == 1 && mdio_oe !== 1'b0) ta1 = 0;
      if (k == 2 && (mdio_oe !== 1'b1 || bus !== 1'b0)) ta2 = 0;
      if (k >= 3 && k <= 18) begin
        if (mdio_oe !== 1'b1) span = 0;
        d[18-k] = bus;
      end
      if (k == 19 && mdio_oe !== 1'b0) span = 0;
    end
    if (hit) begin
      chk(ta1 && ta2, "R7 turnaround", int'({ta1, ta2}), 3);
      chk(span, "R8 drive span", int'(span), 1);
    end else begin
      chk(oe_cnt == o0, req, oe_cnt - o0, 0);
    end
  endtask

  task automatic bad_frame(input bit lead0, input int npre, input bit badstart,
                           input logic [1:0] op, input logic [4:0] pa, input string req);
    int s0, o0;
    s0 = stb_cnt; o0 = oe_cnt;
    if (lead0) put(1'b0);
    preamble(npre);
    if (badstart) begin put(1'b0); put(1'b0); end
    header(op, pa, 5'd3);
    put(1'b1); put(1'b0);
    for (int i = 0; i < 16; i++) put(1'b0);
    repeat (3) @(negedge mdc);
    mst_en = 1'b0;
    chk(stb_cnt == s0 && oe_cnt == o0, req, stb_cnt - s0 + oe_cnt - o0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge mdc);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd, d;
    for (int r = 0; r < 32; r++) expv[r] = '0;
    strap = 3'd5;
    repeat (3) @(negedge mdc);
    chk(mdio_oe === 1'b0 && wr_stb === 1'b0, "R11 reset outputs", int'({mdio_oe, wr_stb}), 0);
    rst_n = 1'b1;
    @(negedge mdc);
    chk(mdio_oe === 1'b0 && wr_stb === 1'b0, "R11 after reset", int'({mdio_oe, wr_stb}), 0);
    do_read(5'd5, 5'd7, 1, "R11", rd);
    chk(rd === 16'h0000, "R11 register reset value", int'(rd), 0);

    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int r = 0; r < 32; r++) begin
        d = 16'(s * 16'h1357 + r * 16'h0F1D + 16'h2468);
        do_write(5'(s), 5'(r), d, 1, "R6");
        expv[r] = d;
      end
      for (int r = 0; r < 32; r++) begin
        do_read(5'(s), 5'(r), 1, "R6", rd);
        chk(rd === expv[r], "R6 R8 read back", int'(rd), int'(expv[r]));
      end
      do_write(5'(s ^ 1), 5'(s), 16'hDEAD, 0, "R4 other low address");
      do_write({2'b01, 3'(s)}, 5'(s), 16'hBEEF, 0, "R4 upper bit 3 set");
      do_write({2'b10, 3'(s)}, 5'(s), 16'hCAFE, 0, "R4 upper bit 4 set");
      do_read({2'b11, 3'(s)}, 5'(s), 0, "R4 read foreign address", rd);
      if (s != 0) begin
        do_write(5'd0, 5'(s), 16'h0BAD, 0, "R5 address 0 not broadcast");
        do_read(5'd0, 5'(s), 0, "R5 read address 0", rd);
      end
      do_read(5'(s), 5'(s), 1, "R4", rd);
      chk(rd === expv[s], "R4 R5 register untouched", int'(rd), int'(expv[s]));
      bad_frame(0, 32, 0, 2'b00, 5'(s), "R3 opcode 00 ignored");
      bad_frame(0, 32, 0, 2'b11, 5'(s), "R3 opcode 11 ignored");
    end

    strap = 3'd2;
    bad_frame(1, 31, 0, 2'b01, 5'd2, "R1 31-one preamble write ignored");
    bad_frame(1, 31, 0, 2'b10, 5'd2, "R1 31-one preamble read ignored");
    bad_frame(1, 32, 1, 2'b01, 5'd2, "R2 bad start pattern");
    do_write(5'd2, 5'd9, 16'h8001, 1, "R2");
    do_read(5'd2, 5'd9, 1, "R2", rd);
    chk(rd === 16'h8001, "R2 recovery after bad start", int'(rd), 16'h8001);
    do_write(5'd2, 5'd31, 16'hFFFF, 1, "R6");
    do_read(5'd2, 5'd31, 1, "R6", rd);
    chk(rd === 16'hFFFF, "R6 top register", int'(rd), 16'hFFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule